// File: doc/BRIEF.md
# Chained-Bucket Hit Sorter

This block sorts incoming hit words into buckets by a bin key so that a later matching stage can fetch every hit of one bin on request. Any number of hits may land in the same bin and none is dropped while free entries remain. Each stored word takes one entry of a data store. Next to it a link store records the entry that held the same key before, so the words of a key form a chain. A key table keeps, for each key, the newest entry of its chain together with the event number that was current when it was written.

A push stores one word in one cycle. A pop names a key. One cycle later the newest word of that key appears with a valid flag and a more-words flag. After that the chain streams out one word per cycle while the consumer's wait input is low. A replay command restarts the most recently popped chain from its newest word, so the same hits can be matched a second time. Starting a new event advances the event number and rewinds the entry allocator. That empties every key in one cycle without clearing any memory, because key-table entries whose event tag no longer matches are treated as empty.

Top module: `hash_chain_sorter`

## Requirements
- R1: After reset `rdy_o` and `md_o` are 0, and a pop of any key leaves `rdy_o` at 0 in the following cycle.
- R2: A pop (`pop_i` high at a clock edge) of a key holding exactly one word sets `rdy_o`=1, `q_o`=that word and `md_o`=0 at that edge.
- R3: The words of one key come out newest first, one per accepted cycle. `md_o` is 1 on every word but the oldest.
- R4: A pop returns only words pushed under its own key, even when pushes to different keys were interleaved.
- R5: While `rdy_o` is 1 and `wait_i` is 1 (with no pop, replay or new event), `rdy_o`, `q_o` and `md_o` hold their values. A word counts as taken at an edge where `rdy_o`=1 and `wait_i`=0.
- R6: When the oldest word (`md_o`=0) is taken, `rdy_o` is 0 after that edge.
- R7: `repop_i` restarts the chain of the most recently popped key from its newest word, even after that chain has ended. When `pop_i` and `repop_i` are high together, the pop wins and its key becomes the one replayed later.
- R8: `new_event_i` drops `rdy_o` at that edge and empties every key. A push or pop in the same cycle is ignored, and a later replay returns nothing.
- R9: After a new event, entries are allocated from the start again, so a full store accepts pushes again.
- R10: At most 2^ID_W words are accepted per event. Further pushes are refused and leave every stored chain unchanged.
- R11: A pop while a chain is still being read abandons that chain and starts the new key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| new_event_i | input | 1 | Start a new event: empty all keys, rewind the allocator |
| push_i | input | 1 | Store `push_data_i` under `push_key_i` |
| push_key_i | input | KEY_W | Bin key of the pushed word |
| push_data_i | input | DATA_W | Hit word to store |
| pop_i | input | 1 | Start reading the chain of `pop_key_i` |
| pop_key_i | input | KEY_W | Bin key to read |
| repop_i | input | 1 | Replay the chain of the last popped key |
| wait_i | input | 1 | Consumer not ready; hold the current word |
| q_o | output | DATA_W | Current output word |
| rdy_o | output | 1 | `q_o` is valid |
| md_o | output | 1 | More words follow the current one |

## Verification
The bench interleaves pushes to neighbouring keys and checks the exact newest-first order and the `md_o` pattern. A design that linked entries globally rather than per key would leak foreign words into a chain. A bad tail flag would end a chain early or run past its oldest entry. Wait stalls on a live word, pops issued mid-chain, and pops issued together with a replay are driven to catch a cursor that advances while stalled, keeps an abandoned chain, or replays the wrong key. The allocator is filled to its last entry and then pushed once more, to catch an off-by-one that wraps the id and overwrites the oldest word. A new event is raised while a chain is live and a push is pending, to catch stale tags that still read as valid or a same-cycle push that slips through.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [1:0] {
    SRC_IDLE  = 2'd0,
    SRC_KEY   = 2'd1,
    SRC_SAVED = 2'd2,
    SRC_NEXT  = 2'd3
  } rd_src_e;
endpackage

// File: rtl/hs_event_ctl.sv
module hs_event_ctl #(
  parameter int ID_W = 8,
  parameter int EV_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            new_event_i,
  input  logic            push_req_i,
  output logic [EV_W-1:0] ev_o,
  output logic [ID_W-1:0] wr_id_o,
  output logic            push_ok_o
);
  logic [ID_W:0]   cnt_q;
  logic [EV_W-1:0] ev_q;
  logic            full;

  assign full      = cnt_q[ID_W];
  assign push_ok_o = push_req_i && !new_event_i && !full;
  assign wr_id_o   = cnt_q[ID_W-1:0];
  assign ev_o      = ev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ev_q  <= '0;
    end else if (new_event_i) begin
      cnt_q <= '0;
      ev_q  <= ev_q + EV_W'(1);
    end else if (push_ok_o) begin
      cnt_q <= cnt_q + (ID_W+1)'(1);
    end
  end
endmodule

// File: rtl/hs_key_table.sv
module hs_key_table #(
  parameter int KEY_W = 9,
  parameter int ID_W  = 8,
  parameter int EV_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EV_W-1:0]  ev_i,
  input  logic [KEY_W-1:0] rd_key_i,
  output logic             rd_hit_o,
  output logic [ID_W-1:0]  rd_head_o,
  input  logic             wr_en_i,
  input  logic [KEY_W-1:0] wr_key_i,
  input  logic [ID_W-1:0]  wr_id_i,
  output logic             wr_hit_o,
  output logic [ID_W-1:0]  wr_head_o
);
  localparam int NKEY = 1 << KEY_W;

  logic [NKEY-1:0] vld_q;
  logic [EV_W-1:0] tag_q  [NKEY];
  logic [ID_W-1:0] head_q [NKEY];

  // an entry is live only if written during the current event
  assign rd_hit_o  = vld_q[rd_key_i] && (tag_q[rd_key_i] == ev_i);
  assign rd_head_o = head_q[rd_key_i];
  assign wr_hit_o  = vld_q[wr_key_i] && (tag_q[wr_key_i] == ev_i);
  assign wr_head_o = head_q[wr_key_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else if (wr_en_i) vld_q[wr_key_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_key_i]  <= ev_i;
      head_q[wr_key_i] <= wr_id_i;
    end
  end
endmodule

// File: rtl/hs_link_mem.sv
module hs_link_mem #(
  parameter int ID_W   = 8,
  parameter int DATA_W = 28
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [ID_W-1:0]   wr_id_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_has_next_i,
  input  logic [ID_W-1:0]   wr_next_i,
  input  logic [ID_W-1:0]   rd_id_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_has_next_o,
  output logic [ID_W-1:0]   rd_next_o
);
  localparam int DEPTH = 1 << ID_W;
  localparam int LNK_W = ID_W + 1;

  logic [DATA_W-1:0] data_q [DEPTH];
  logic [LNK_W-1:0]  link_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      data_q[wr_id_i] <= wr_data_i;
      link_q[wr_id_i] <= {wr_has_next_i, wr_next_i};
    end
  end

  assign rd_data_o     = data_q[rd_id_i];
  assign rd_has_next_o = link_q[rd_id_i][ID_W];
  assign rd_next_o     = link_q[rd_id_i][ID_W-1:0];
endmodule

// File: rtl/hs_read_ctl.sv
module hs_read_ctl
  import hs_pkg::*;
#(
  parameter int ID_W   = 8,
  parameter int DATA_W = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              pop_i,
  input  logic              repop_i,
  input  logic              wait_i,
  input  logic              key_hit_i,
  input  logic [ID_W-1:0]   key_head_i,
  output logic [ID_W-1:0]   rd_id_o,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              rd_has_next_i,
  input  logic [ID_W-1:0]   rd_next_i,
  output logic [DATA_W-1:0] q_o,
  output logic              rdy_o,
  output logic              md_o
);
  logic [DATA_W-1:0] q_q;
  logic              rdy_q, md_q;
  logic [ID_W-1:0]   nxt_q, saved_id_q;
  logic              saved_ok_q;
  rd_src_e           src;
  logic              take, src_ok;

  assign take = rdy_q && !wait_i;

  always_comb begin
    if (pop_i)              src = SRC_KEY;
    else if (repop_i)       src = SRC_SAVED;
    else if (take && md_q)  src = SRC_NEXT;
    else                    src = SRC_IDLE;
  end

  always_comb begin
    unique case (src)
      SRC_KEY:   begin rd_id_o = key_head_i; src_ok = key_hit_i;  end
      SRC_SAVED: begin rd_id_o = saved_id_q; src_ok = saved_ok_q; end
      SRC_NEXT:  begin rd_id_o = nxt_q;      src_ok = 1'b1;       end
      default:   begin rd_id_o = nxt_q;      src_ok = 1'b0;       end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q      <= 1'b0;
      md_q       <= 1'b0;
      q_q        <= '0;
      nxt_q      <= '0;
      saved_id_q <= '0;
      saved_ok_q <= 1'b0;
    end else if (flush_i) begin
      rdy_q      <= 1'b0;
      md_q       <= 1'b0;
      saved_ok_q <= 1'b0;
    end else if (src != SRC_IDLE) begin
      rdy_q <= src_ok;
      md_q  <= src_ok && rd_has_next_i;
      q_q   <= rd_data_i;
      nxt_q <= rd_next_i;
      if (src == SRC_KEY) begin
        saved_id_q <= key_head_i;
        saved_ok_q <= key_hit_i;
      end
    end else if (take) begin
      rdy_q <= 1'b0;
      md_q  <= 1'b0;
    end
  end

  assign q_o   = q_q;
  assign rdy_o = rdy_q;
  assign md_o  = md_q;
endmodule

// File: rtl/hash_chain_sorter.sv
module hash_chain_sorter #(
  parameter int KEY_W  = 9,
  parameter int DATA_W = 28,
  parameter int ID_W   = 8,
  parameter int EV_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              new_event_i,
  input  logic              push_i,
  input  logic [KEY_W-1:0]  push_key_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  input  logic [KEY_W-1:0]  pop_key_i,
  input  logic              repop_i,
  input  logic              wait_i,
  output logic [DATA_W-1:0] q_o,
  output logic              rdy_o,
  output logic              md_o
);
  logic [EV_W-1:0]   ev;
  logic [ID_W-1:0]   wr_id, wr_head, rd_head, rd_id, rd_next;
  logic              push_ok, wr_hit, rd_hit, rd_has_next;
  logic [DATA_W-1:0] rd_data;

  hs_event_ctl #(.ID_W(ID_W), .EV_W(EV_W)) u_ev (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .new_event_i (new_event_i),
    .push_req_i  (push_i),
    .ev_o        (ev),
    .wr_id_o     (wr_id),
    .push_ok_o   (push_ok)
  );

  hs_key_table #(.KEY_W(KEY_W), .ID_W(ID_W), .EV_W(EV_W)) u_keys (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ev_i      (ev),
    .rd_key_i  (pop_key_i),
    .rd_hit_o  (rd_hit),
    .rd_head_o (rd_head),
    .wr_en_i   (push_ok),
    .wr_key_i  (push_key_i),
    .wr_id_i   (wr_id),
    .wr_hit_o  (wr_hit),
    .wr_head_o (wr_head)
  );

  // new entry becomes head; the old head (if live) is its successor
  hs_link_mem #(.ID_W(ID_W), .DATA_W(DATA_W)) u_mem (
    .clk_i         (clk_i),
    .wr_en_i       (push_ok),
    .wr_id_i       (wr_id),
    .wr_data_i     (push_data_i),
    .wr_has_next_i (wr_hit),
    .wr_next_i     (wr_head),
    .rd_id_i       (rd_id),
    .rd_data_o     (rd_data),
    .rd_has_next_o (rd_has_next),
    .rd_next_o     (rd_next)
  );

  hs_read_ctl #(.ID_W(ID_W), .DATA_W(DATA_W)) u_rd (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .flush_i       (new_event_i),
    .pop_i         (pop_i),
    .repop_i       (repop_i),
    .wait_i        (wait_i),
    .key_hit_i     (rd_hit),
    .key_head_i    (rd_head),
    .rd_id_o       (rd_id),
    .rd_data_i     (rd_data),
    .rd_has_next_i (rd_has_next),
    .rd_next_i     (rd_next),
    .q_o           (q_o),
    .rdy_o         (rdy_o),
    .md_o          (md_o)
  );
endmodule

// File: rtl/hash_chain_sorter_chk.sv
module hash_chain_sorter_chk #(
  parameter int DATA_W = 28
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              new_event_i,
  input logic              pop_i,
  input logic              repop_i,
  input logic              wait_i,
  input logic [DATA_W-1:0] q_o,
  input logic              rdy_o,
  input logic              md_o
);
  // R3: more-words flag only on a valid word
  a_r3_md_needs_rdy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    md_o |-> rdy_o);

  // R5: stalled word holds
  a_r5_wait_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_o && wait_i && !pop_i && !repop_i && !new_event_i)
      |=> (rdy_o && $stable(q_o) && $stable(md_o)));

  // R6: taking the oldest word ends the chain
  a_r6_tail_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_o && !md_o && !wait_i && !pop_i && !repop_i && !new_event_i) |=> !rdy_o);

  // R8: new event drops the output
  a_r8_flush_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_event_i |=> !rdy_o);

  // R8: replay right after a new event has nothing to return
  a_r8_no_replay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(new_event_i) && repop_i && !pop_i && !new_event_i) |=> !rdy_o);
endmodule

bind hash_chain_sorter hash_chain_sorter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .new_event_i (new_event_i),
  .pop_i       (pop_i),
  .repop_i     (repop_i),
  .wait_i      (wait_i),
  .q_o         (q_o),
  .rdy_o       (rdy_o),
  .md_o        (md_o)
);

// File: tb/hash_chain_sorter_test.sv
module hash_chain_sorter_test;
  localparam int KEY_W = 9;
  localparam int DATA_W = 28;
  localparam int ID_W = 8;
  localparam int EV_W = 8;
  localparam int DEPTH = 1 << ID_W;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic new_event_i = 1'b0, push_i = 1'b0, pop_i = 1'b0, repop_i = 1'b0, wait_i = 1'b0;
  logic [KEY_W-1:0] push_key_i = '0, pop_key_i = '0;
  logic [DATA_W-1:0] push_data_i = '0;
  logic [DATA_W-1:0] q_o;
  logic rdy_o, md_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hash_chain_sorter #(.KEY_W(KEY_W), .DATA_W(DATA_W), .ID_W(ID_W), .EV_W(EV_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .new_event_i(new_event_i),
    .push_i(push_i), .push_key_i(push_key_i), .push_data_i(push_data_i),
    .pop_i(pop_i), .pop_key_i(pop_key_i), .repop_i(repop_i), .wait_i(wait_i),
    .q_o(q_o), .rdy_o(rdy_o), .md_o(md_o)
  );

  function automatic logic [DATA_W-1:0] dat(input int k, input int i);
    return DATA_W'(32'h0A0_0000 + k * 4096 + i);
  endfunction

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic push(input int k, input logic [DATA_W-1:0] d);
    push_i = 1'b1; push_key_i = KEY_W'(k); push_data_i = d;
    cyc();
    push_i = 1'b0;
  endtask

  task automatic pop(input int k);
    pop_i = 1'b1; pop_key_i = KEY_W'(k);
    cyc();
    pop_i = 1'b0;
  endtask

  task automatic replay();
    repop_i = 1'b1;
    cyc();
    repop_i = 1'b0;
  endtask

  // check current word, then let it be taken
  task automatic take_word(input string rq, input logic [DATA_W-1:0] d, input bit md);
    chk(rdy_o === 1'b1, rq, rdy_o, 1);
    chk(q_o === d, rq, q_o, d);
    chk(md_o === md, rq, md_o, md);
    cyc();
  endtask

  task automatic expect_none(input string rq);
    chk(rdy_o === 1'b0, rq, rdy_o, 0);
    chk(md_o === 1'b0, rq, md_o, 0);
  endtask

  task automatic t_reset();
    expect_none("R1 reset");
    pop(5);
    expect_none("R1 empty pop");
  endtask

  task automatic t_single();
    push(3, dat(3, 0));
    pop(3);
    take_word("R2 single", dat(3, 0), 1'b0);
    expect_none("R6 end after single");
  endtask

  task automatic t_chain();
    for (int i = 0; i < 5; i++) begin
      push(7, dat(7, i));
      if (i < 2) push(8, dat(8, i));
    end
    pop(7);
    for (int i = 4; i >= 0; i--) take_word("R3 R4 chain key7", dat(7, i), i != 0);
    expect_none("R6 end key7");
    pop(8);
    take_word("R4 key8", dat(8, 1), 1'b1);
    take_word("R4 key8", dat(8, 0), 1'b0);
    expect_none("R6 end key8");
  endtask

  task automatic t_wait();
    pop(7);
    wait_i = 1'b1;
    for (int c = 0; c < 3; c++) begin
      chk(rdy_o === 1'b1 && q_o === dat(7, 4) && md_o === 1'b1, "R5 hold", q_o, dat(7, 4));
      cyc();
    end
    wait_i = 1'b0;
    take_word("R5 after stall", dat(7, 4), 1'b1);
    take_word("R5 next", dat(7, 3), 1'b1);
    wait_i = 1'b1;
    cyc();
    chk(q_o === dat(7, 2), "R5 hold mid", q_o, dat(7, 2));
    wait_i = 1'b0;
    for (int i = 2; i >= 0; i--) take_word("R5 drain", dat(7, i), i != 0);
    expect_none("R6 end after stall");
  endtask

  task automatic t_replay();
    replay();
    for (int i = 4; i >= 0; i--) take_word("R7 replay key7", dat(7, i), i != 0);
    expect_none("R7 replay end");
    pop(8);
    take_word("R7 key8 first", dat(8, 1), 1'b1);
    replay();
    take_word("R7 replay mid", dat(8, 1), 1'b1);
    take_word("R7 replay mid", dat(8, 0), 1'b0);
    pop_i = 1'b1; repop_i = 1'b1; pop_key_i = KEY_W'(3);
    cyc();
    pop_i = 1'b0; repop_i = 1'b0;
    take_word("R7 pop wins", dat(3, 0), 1'b0);
    replay();
    take_word("R7 saved follows pop", dat(3, 0), 1'b0);
    expect_none("R7 end");
  endtask

  task automatic t_abandon();
    pop(7);
    take_word("R11 first", dat(7, 4), 1'b1);
    pop(3);
    take_word("R11 switched", dat(3, 0), 1'b0);
    expect_none("R11 end");
  endtask

  task automatic t_event();
    pop(7);
    chk(rdy_o === 1'b1, "R8 live before", rdy_o, 1);
    new_event_i = 1'b1; push_i = 1'b1; push_key_i = KEY_W'(9); push_data_i = dat(9, 0);
    cyc();
    new_event_i = 1'b0; push_i = 1'b0;
    expect_none("R8 drop");
    replay();
    expect_none("R8 replay empty");
    pop(7);
    expect_none("R8 key7 empty");
    pop(9);
    expect_none("R8 same-cycle push ignored");
    new_event_i = 1'b1; pop_i = 1'b1; pop_key_i = KEY_W'(9);
    cyc();
    new_event_i = 1'b0; pop_i = 1'b0;
    expect_none("R8 same-cycle pop ignored");
  endtask

  task automatic t_capacity();
    for (int i = 0; i < DEPTH; i++) push(1, dat(1, i));
    push(2, dat(2, 0));
    pop(2);
    expect_none("R10 refused push");
    pop(1);
    for (int i = DEPTH - 1; i >= 0; i--) take_word("R10 full chain intact", dat(1, i), i != 0);
    expect_none("R10 end");
    new_event_i = 1'b1;
    cyc();
    new_event_i = 1'b0;
    push(2, dat(2, 5));
    pop(2);
    take_word("R9 reuse after event", dat(2, 5), 1'b0);
    pop(1);
    expect_none("R9 old key empty");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) cyc();
    rst_ni = 1'b1;
    cyc();
    t_reset();
    t_single();
    t_chain();
    t_wait();
    t_replay();
    t_abandon();
    t_event();
    t_capacity();
    finish_run();
  end
endmodule